// File: doc/BRIEF.md
# SPI Serial Memory Command Front-End

This block is the slave-side serial engine that sits in front of a byte-addressed memory array. It watches the serial clock, the active-low select, the serial input line and an active-low pause input, all sampled in the core clock domain. From these it assembles an 8-bit command, an optional 16-bit address and any data bytes. It turns the command into single-cycle requests for a status/protection unit and a page-write sequencer. For reads it fetches bytes through a synchronous read port and shifts them out most significant bit first on the serial output, which has its own drive enable.

SPI modes 0 and 3 are accepted. Input bits are taken on serial-clock rising edges and output bits change on falling edges. The serial clock must stay high and low for at least three core clocks each. The `ADDR_W` parameter selects 16 or 15 array address bits, and with 15 the top received address bit is dropped. `PAGE_W` sets how many low address bits step during a page write.

FSM states: `ST_IDLE` (deselected), `ST_OPC` (command byte), `ST_ADDR` (16 address bits), `ST_RD` (array streaming), `ST_SRO` (status streaming), `ST_SRI` (status byte in), `ST_SRH` (status byte held, waiting for deselect), `ST_WR` (page data in), `ST_DONE` (command finished, further bits ignored) and `ST_LOCK` (bad command, interface dead until reselect).

Transitions:
- Any state goes to `ST_IDLE` while select is high. `ST_IDLE` goes to `ST_OPC` once select is low.
- From `ST_OPC`, on the eighth bit: to `ST_DONE` (enable, disable, or any command other than status read while busy), `ST_SRO`, `ST_SRI`, `ST_ADDR`, or `ST_LOCK`.
- `ST_ADDR` goes to `ST_RD` or `ST_WR` on the sixteenth bit.
- `ST_SRI` goes to `ST_SRH` on its eighth bit. `ST_SRH` goes to `ST_DONE` on any further bit.

Top module: `spi_mem_frontend`

## Requirements
- R1: The command byte is decoded with bits 7..4 required zero and bit 3 ignored. The low three bits select the command: 110 write-enable, 100 write-disable, 101 status read, 001 status write, 011 array read, 010 page write. Enable and disable each give one `req_wren`/`req_wrdi` pulse after the eighth bit.
- R2: While `cs_n` is high, serial-clock activity on `si` produces no request and `so_en` stays low. A transaction starts at a falling edge of `cs_n`, and every field is taken most significant bit first.
- R3: Any other command byte locks the interface. No request or data strobe follows, and `so_en` stays low until `cs_n` rises and falls again.
- R4: When `hold_n` is taken low while `sck` is low, `so_en` goes low and clock edges are ignored. When `hold_n` is raised again while `sck` is low, the transfer continues with no bit lost.
- R5: Array read takes a 16-bit address. From the first falling edge after the last address bit, it shifts out the array byte at that address, then the bytes at following addresses.
- R6: An array read passing the highest address continues at address zero.
- R7: Status read shifts out `stat_byte`, sampled when each byte starts, and repeats it for as long as clocks continue.
- R8: During page write, each complete data byte gives one `wr_vld` pulse with `wr_addr` and `wr_data`. Only the low `PAGE_W` address bits step, and they wrap inside the page. A `cs_n` rise on a byte boundary after at least one byte gives one `wr_commit` pulse.
- R9: Status write captures one data byte into `sr_data`. A `cs_n` rise directly after that byte gives one `sr_commit` pulse.
- R10: While `busy` is high, every command except status read is ignored with no strobe.
- R11: A `cs_n` rise in the middle of a byte, or after extra bits following the status byte, produces no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | asynchronous active-low reset |
| sck | input | 1 | serial clock (core-synchronous) |
| cs_n | input | 1 | active-low select |
| si | input | 1 | serial data in |
| hold_n | input | 1 | active-low pause |
| so | output | 1 | serial data out |
| so_en | output | 1 | drive enable for `so` |
| busy | input | 1 | internal write cycle running |
| stat_byte | input | 8 | status byte to transmit |
| arr_rd | output | 1 | array read strobe |
| arr_addr | output | ADDR_W | array read address |
| arr_data | input | 8 | read data, valid the cycle after `arr_rd` |
| req_wren | output | 1 | write-enable request |
| req_wrdi | output | 1 | write-disable request |
| wr_vld | output | 1 | page data byte strobe |
| wr_addr | output | ADDR_W | page data byte address |
| wr_data | output | 8 | page data byte |
| wr_commit | output | 1 | start programming the page |
| sr_data | output | 8 | received status byte |
| sr_commit | output | 1 | start the status write |

## Verification
On the rising edge that completes a read byte, the block issues the next array fetch and steps the address counter in the same clock. When the counter is at the top of the space, the same clock also wraps it to zero. This is provoked by reading from address 0xFFFF and judged by the second byte equalling the model value for address zero. The page-write byte strobe and the in-page address wrap likewise fall together. A write started at 0x127E must report its third byte at 0x1200.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_RD, ST_SRO,
        ST_SRI, ST_SRH, ST_WR, ST_DONE, ST_LOCK
    } fe_state_e;

    typedef enum logic [2:0] {
        CMD_WREN, CMD_WRDI, CMD_RDSR, CMD_WRSR, CMD_READ, CMD_WRITE, CMD_BAD
    } fe_cmd_e;

    function automatic fe_cmd_e decode_op(input logic [7:0] b);
        fe_cmd_e c;
        if (b[7:4] != 4'h0) begin
            c = CMD_BAD;
        end else begin
            unique case (b[2:0])
                3'b110:  c = CMD_WREN;
                3'b100:  c = CMD_WRDI;
                3'b101:  c = CMD_RDSR;
                3'b001:  c = CMD_WRSR;
                3'b011:  c = CMD_READ;
                3'b010:  c = CMD_WRITE;
                default: c = CMD_BAD;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/spi_fe_pins.sv
module spi_fe_pins (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic hold_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic held
);
    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            held  <= 1'b0;
        end else begin
            sck_q <= sck;
            if (cs_n)
                held <= 1'b0;
            else if (!sck)
                held <= !hold_n;
        end
    end

    assign sck_rise = !cs_n && !held && sck && !sck_q;
    assign sck_fall = !cs_n && !held && !sck && sck_q;

    // R4
    hold_low_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> !$past(sck));

endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
    import spi_fe_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              si,
    input  logic              sck_rise,
    input  logic              busy,
    output logic              tx_act,
    output logic              ld_req,
    output logic              ld_arr,
    output logic              arr_rd,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              req_wren,
    output logic              req_wrdi,
    output logic              wr_vld,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit,
    output logic [7:0]        sr_data,
    output logic              sr_commit
);
    localparam logic [ADDR_W-1:0] ONE_A = 1;
    localparam logic [PAGE_W-1:0] ONE_P = 1;

    fe_state_e         st;
    logic [3:0]        bcnt;
    logic [14:0]       sh;
    logic [ADDR_W-1:0] addr;
    logic              is_rd;
    logic              got;

    logic        rise_done;
    logic [7:0]  in_byte;
    logic [15:0] in_word;
    fe_cmd_e     cmd;
    logic        opc_skip;

    always_comb begin
        in_byte   = {sh[6:0], si};
        in_word   = {sh, si};
        cmd       = decode_op(in_byte);
        rise_done = sck_rise && ((st == ST_ADDR) ? (bcnt == 4'd15) : (bcnt[2:0] == 3'd7));
        opc_skip  = busy && (cmd != CMD_RDSR);
        tx_act    = (st == ST_RD) || (st == ST_SRO);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            bcnt  <= '0;
            sh    <= '0;
            addr  <= '0;
            is_rd <= 1'b0;
            got   <= 1'b0;
        end else if (cs_n) begin
            st   <= ST_IDLE;
            bcnt <= '0;
            got  <= 1'b0;
        end else if (st == ST_IDLE) begin
            st   <= ST_OPC;
            bcnt <= '0;
        end else if (sck_rise) begin
            sh   <= {sh[13:0], si};
            bcnt <= rise_done ? 4'd0 : bcnt + 4'd1;
            unique case (st)
                ST_OPC: if (rise_done) begin
                    if (opc_skip) begin
                        st <= ST_DONE;
                    end else begin
                        unique case (cmd)
                            CMD_WREN, CMD_WRDI: st <= ST_DONE;
                            CMD_RDSR:  st <= ST_SRO;
                            CMD_WRSR:  st <= ST_SRI;
                            CMD_READ:  begin st <= ST_ADDR; is_rd <= 1'b1; end
                            CMD_WRITE: begin st <= ST_ADDR; is_rd <= 1'b0; end
                            default:   st <= ST_LOCK;
                        endcase
                    end
                end
                ST_ADDR: if (rise_done) begin
                    addr <= is_rd ? in_word[ADDR_W-1:0] + ONE_A : in_word[ADDR_W-1:0];
                    st   <= is_rd ? ST_RD : ST_WR;
                end
                ST_RD: if (rise_done) addr <= addr + ONE_A;
                ST_WR: if (rise_done) begin
                    addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + ONE_P};
                    got  <= 1'b1;
                end
                ST_SRI: if (rise_done) st <= ST_SRH;
                ST_SRH: st <= ST_DONE;
                default: ;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_wren  <= 1'b0;
            req_wrdi  <= 1'b0;
            wr_vld    <= 1'b0;
            wr_commit <= 1'b0;
            sr_commit <= 1'b0;
            arr_rd    <= 1'b0;
            ld_req    <= 1'b0;
            ld_arr    <= 1'b0;
            arr_addr  <= '0;
            wr_addr   <= '0;
            wr_data   <= '0;
            sr_data   <= '0;
        end else begin
            req_wren  <= 1'b0;
            req_wrdi  <= 1'b0;
            wr_vld    <= 1'b0;
            wr_commit <= 1'b0;
            sr_commit <= 1'b0;
            arr_rd    <= 1'b0;
            ld_req    <= 1'b0;
            if (cs_n) begin
                wr_commit <= (st == ST_WR) && (bcnt == 4'd0) && got;
                sr_commit <= (st == ST_SRH);
            end else if (rise_done) begin
                unique case (st)
                    ST_OPC: if (!opc_skip) begin
                        req_wren <= (cmd == CMD_WREN);
                        req_wrdi <= (cmd == CMD_WRDI);
                        if (cmd == CMD_RDSR) begin
                            ld_req <= 1'b1;
                            ld_arr <= 1'b0;
                        end
                    end
                    ST_ADDR: if (is_rd) begin
                        arr_rd   <= 1'b1;
                        arr_addr <= in_word[ADDR_W-1:0];
                        ld_req   <= 1'b1;
                        ld_arr   <= 1'b1;
                    end
                    ST_RD: begin
                        arr_rd   <= 1'b1;
                        arr_addr <= addr;
                        ld_req   <= 1'b1;
                        ld_arr   <= 1'b1;
                    end
                    ST_SRO: begin
                        ld_req <= 1'b1;
                        ld_arr <= 1'b0;
                    end
                    ST_WR: begin
                        wr_vld  <= 1'b1;
                        wr_addr <= addr;
                        wr_data <= in_byte;
                    end
                    ST_SRI: sr_data <= in_byte;
                    default: ;
                endcase
            end
        end
    end

    // R2
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (st == ST_IDLE));

    // R3
    lock_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOCK && !cs_n) |=> (st == ST_LOCK));

    // R10
    busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OPC && !cs_n && rise_done && opc_skip)
            |=> (st == ST_DONE && !req_wren && !req_wrdi));

    // R1
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_wren, req_wrdi, wr_vld, arr_rd, wr_commit, sr_commit}));

endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck_fall,
    input  logic       ld_req,
    input  logic       ld_arr,
    input  logic       arr_rd,
    input  logic [7:0] arr_data,
    input  logic [7:0] stat_byte,
    output logic       so
);
    logic       rd_pend;
    logic [7:0] nxt;
    logic       pend_ld;
    logic       pend_arr;
    logic [7:0] osh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_pend  <= 1'b0;
            nxt      <= '0;
            pend_ld  <= 1'b0;
            pend_arr <= 1'b0;
            osh      <= '0;
        end else begin
            rd_pend <= arr_rd;
            if (rd_pend)
                nxt <= arr_data;
            if (cs_n) begin
                pend_ld <= 1'b0;
            end else if (ld_req) begin
                pend_ld  <= 1'b1;
                pend_arr <= ld_arr;
            end else if (sck_fall) begin
                if (pend_ld) begin
                    osh     <= pend_arr ? nxt : stat_byte;
                    pend_ld <= 1'b0;
                end else begin
                    osh <= {osh[6:0], 1'b0};
                end
            end
        end
    end

    assign so = osh[7];

    // R5
    fetch_before_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_fall && pend_ld && pend_arr) |-> !rd_pend);

endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_en,
    input  logic              busy,
    input  logic [7:0]        stat_byte,
    output logic              arr_rd,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [7:0]        arr_data,
    output logic              req_wren,
    output logic              req_wrdi,
    output logic              wr_vld,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit,
    output logic [7:0]        sr_data,
    output logic              sr_commit
);
    logic sck_rise, sck_fall, held;
    logic tx_act, ld_req, ld_arr;

    spi_fe_pins u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .hold_n   (hold_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .held     (held)
    );

    spi_fe_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .si        (si),
        .sck_rise  (sck_rise),
        .busy      (busy),
        .tx_act    (tx_act),
        .ld_req    (ld_req),
        .ld_arr    (ld_arr),
        .arr_rd    (arr_rd),
        .arr_addr  (arr_addr),
        .req_wren  (req_wren),
        .req_wrdi  (req_wrdi),
        .wr_vld    (wr_vld),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_commit (wr_commit),
        .sr_data   (sr_data),
        .sr_commit (sr_commit)
    );

    spi_fe_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck_fall  (sck_fall),
        .ld_req    (ld_req),
        .ld_arr    (ld_arr),
        .arr_rd    (arr_rd),
        .arr_data  (arr_data),
        .stat_byte (stat_byte),
        .so        (so)
    );

    assign so_en = tx_act && !held && !cs_n;

    // R4
    held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && $past(held)) |-> !sck_rise && !sck_fall);

endmodule

// File: tb/spi_mem_frontend_bench.sv
module spi_mem_frontend_bench;
    localparam int CLK_P = 10;
    localparam int HALF  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
    logic [7:0] stat_byte = 8'h00;
    logic so, so_en, arr_rd, req_wren, req_wrdi, wr_vld, wr_commit, sr_commit;
    logic [15:0] arr_addr, wr_addr;
    logic [7:0] arr_data, wr_data, sr_data, mem_q;

    int errors = 0, checks = 0;
    int n_wren = 0, n_wrdi = 0, n_wr = 0, n_wc = 0, n_sc = 0;
    logic [15:0] last_wa = '0;
    logic [7:0]  last_wd = '0;
    logic oe_any = 1'b0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    spi_mem_frontend u_spi_mem_frontend (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
        .so(so), .so_en(so_en), .busy(busy), .stat_byte(stat_byte),
        .arr_rd(arr_rd), .arr_addr(arr_addr), .arr_data(arr_data),
        .req_wren(req_wren), .req_wrdi(req_wrdi), .wr_vld(wr_vld),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
        .sr_data(sr_data), .sr_commit(sr_commit));

    function automatic logic [7:0] mval(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        if (arr_rd) mem_q <= mval(arr_addr);
        if (rst_n) begin
            n_wren <= n_wren + int'(req_wren);
            n_wrdi <= n_wrdi + int'(req_wrdi);
            n_wr   <= n_wr + int'(wr_vld);
            n_wc   <= n_wc + int'(wr_commit);
            n_sc   <= n_sc + int'(sr_commit);
            if (wr_vld) begin last_wa <= wr_addr; last_wd <= wr_data; end
        end
    end
    assign arr_data = mem_q;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bit_x(input logic b, output logic o);
        si = b;
        repeat (HALF) @(negedge clk);
        o = so;
        oe_any = oe_any | so_en;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic byte_x(input logic [7:0] b, output logic [7:0] o);
        for (int i = 7; i >= 0; i--) bit_x(b[i], o[i]);
    endtask

    task automatic cs_lo();
        @(negedge clk); cs_n = 1'b0; oe_any = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (2) @(negedge clk); cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // {opcode, expect: 1 enable, 2 disable, 3 lock}
    localparam logic [9:0] VEC [8] = '{
        {8'h06, 2'd1}, {8'h0E, 2'd1}, {8'h04, 2'd2}, {8'h0C, 2'd2},
        {8'h07, 2'd3}, {8'h00, 2'd3}, {8'h16, 2'd3}, {8'h86, 2'd3}};

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] d, d2;
        logic ob;
        int w0, d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 reset so_en", so_en, 0);
        check("R2 reset strobes", n_wren + n_wr + n_wc, 0);

        // R1 R3 opcode table
        for (int v = 0; v < 8; v++) begin
            w0 = n_wren; d0 = n_wrdi;
            cs_lo();
            byte_x(VEC[v][9:2], d);
            byte_x(8'h06, d);
            check($sformatf("R1 enable op %0h", VEC[v][9:2]), n_wren - w0, VEC[v][1:0] == 2'd1);
            check($sformatf("R1 disable op %0h", VEC[v][9:2]), n_wrdi - d0, VEC[v][1:0] == 2'd2);
            if (VEC[v][1:0] == 2'd3) check("R3 lock so_en", oe_any, 0);
            cs_hi();
        end
        w0 = n_wren;
        cs_lo(); byte_x(8'h06, d); cs_hi();
        check("R3 reselect clears lock", n_wren - w0, 1);

        // R2 clocks with cs high are ignored
        w0 = n_wren; oe_any = 1'b0;
        byte_x(8'h06, d);
        check("R2 deselected strobe", n_wren - w0, 0);
        check("R2 deselected so_en", oe_any, 0);

        // R5 read
        cs_lo();
        byte_x(8'h03, d); byte_x(8'h34, d); byte_x(8'hA1, d);
        byte_x(8'hFF, d);  check("R5 first byte", d, mval(16'h34A1));
        check("R5 so_en during read", oe_any, 1);
        byte_x(8'h00, d);  check("R5 next byte", d, mval(16'h34A2));
        cs_hi();

        // R6 wrap
        cs_lo();
        byte_x(8'h03, d); byte_x(8'hFF, d); byte_x(8'hFF, d);
        byte_x(8'h00, d);  check("R6 top byte", d, mval(16'hFFFF));
        byte_x(8'h00, d);  check("R6 wrap to zero", d, mval(16'h0000));
        cs_hi();

        // R4 hold mid byte
        cs_lo();
        byte_x(8'h03, d); byte_x(8'h12, d); byte_x(8'h34, d);
        for (int i = 7; i >= 5; i--) bit_x(1'b0, d[i]);
        hold_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R4 so_en in hold", so_en, 0);
        for (int k = 0; k < 2; k++) begin
            sck = 1'b1; si = k[0]; repeat (HALF) @(negedge clk);
            sck = 1'b0; repeat (HALF) @(negedge clk);
        end
        hold_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 4; i >= 0; i--) bit_x(1'b0, d[i]);
        check("R4 byte across hold", d, mval(16'h1234));
        byte_x(8'h00, d);  check("R4 following byte", d, mval(16'h1235));
        cs_hi();

        // R8 page write with in-page wrap
        w0 = n_wr; d0 = n_wc;
        cs_lo();
        byte_x(8'h02, d); byte_x(8'h12, d); byte_x(8'h7E, d);
        byte_x(8'h11, d); byte_x(8'h22, d); byte_x(8'h33, d);
        cs_hi();
        check("R8 byte strobes", n_wr - w0, 3);
        check("R8 wrapped addr", last_wa, 16'h1200);
        check("R8 last data", last_wd, 8'h33);
        check("R8 commit", n_wc - d0, 1);

        // R11 write aborted mid byte
        w0 = n_wr; d0 = n_wc;
        cs_lo();
        byte_x(8'h02, d); byte_x(8'h00, d); byte_x(8'h10, d); byte_x(8'hAB, d);
        for (int i = 0; i < 4; i++) bit_x(1'b1, ob);
        cs_hi();
        check("R11 aborted write strobes", n_wr - w0, 1);
        check("R11 aborted write commit", n_wc - d0, 0);

        // R9 status write
        d0 = n_sc;
        cs_lo(); byte_x(8'h01, d); byte_x(8'h8C, d); cs_hi();
        check("R9 status commit", n_sc - d0, 1);
        check("R9 status data", sr_data, 8'h8C);
        d0 = n_sc;
        cs_lo(); byte_x(8'h09, d); byte_x(8'h04, d);
        for (int i = 0; i < 3; i++) bit_x(1'b0, ob);
        cs_hi();
        check("R11 status extra bits", n_sc - d0, 0);

        // R7 R10 status read in mode 3 while busy
        busy = 1'b1; stat_byte = 8'hA5;
        sck = 1'b1;
        cs_lo();
        sck = 1'b0; repeat (HALF) @(negedge clk);
        byte_x(8'h05, d);
        byte_x(8'h00, d); check("R7 status byte", d, 8'hA5);
        stat_byte = 8'h3C;
        byte_x(8'h00, d); check("R7 status repeat", d, 8'h3C);
        cs_hi();
        w0 = n_wren; d0 = n_wr;
        cs_lo(); byte_x(8'h06, d); cs_hi();
        cs_lo(); byte_x(8'h02, d); byte_x(8'h00, d); byte_x(8'h00, d); byte_x(8'h55, d); cs_hi();
        check("R10 enable ignored", n_wren - w0, 0);
        check("R10 write ignored", n_wr - d0, 0);
        busy = 1'b0;

        finish_run();
    end
endmodule